// File: doc/BRIEF.md
# Hybrid Arbiter/Oscillator Response Generator

This block sequences and measures a challenge-response unit that draws on two entropy sources. The sources are edge races through delay paths and frequency differences between ring oscillators. A start strobe does several things: it captures a challenge word and a window length, raises busy, and emits a one-cycle launch pulse toward the delay paths.

Every stage uses its slice of the challenge to pick one of several return paths on each of its two sides. An arbiter then records which side's edge arrives first. That arbiter bit chooses which of the stage's two oscillator pairs is measured. During the window, two gated counters count rising edges of the chosen pair. The comparison of those counts gives the stage bit.

Stage bits are XOR-folded in groups into the response word. The response is loaded together with a one-cycle done pulse. The delay paths and oscillators stay outside the block, and every such input is asynchronous. Each one passes through a two-flop synchronizer before it is used.

Top module: `hybrid_resp_gen`

## Requirements
- R1: After reset, busy_o, done_o and launch_o are 0 and resp_o is all zeros.
- R2: A start_i sampled high while idle causes the following. It captures chal_i and window_i. launch_o and busy_o go high in the next cycle, and launch_o stays high for exactly one cycle.
- R3: Stage s races the A-side line path_a_i[s*PATHS+k] against the B-side line path_b_i[s*PATHS+k]. The index k is the challenge field chal_i[s*SEL_W +: SEL_W] (SEL_W=2, PATHS=4). The other path lines are ignored.
- R4: A stage's arbiter bit is 1 when its synchronized A edge is seen strictly earlier than its B edge. When B is seen first, or both are seen in the same cycle, the bit is 0.
- R5: A stage whose two selected edges have not both arrived within RACE_TO cycles after launch takes arbiter bit 0. The race phase then ends after exactly RACE_TO cycles. It ends earlier once every stage has seen both edges.
- R6: Stage s compares oscillator pair (ro_i[4s], ro_i[4s+1]) when its arbiter bit is 0, and pair (ro_i[4s+2], ro_i[4s+3]) when it is 1. The lower-indexed line of a pair is the first oscillator.
- R7: A stage bit is 1 when the first oscillator's rising-edge count over the window is strictly greater than the second's. On a tie the stage bit is 0.
- R8: The measurement window lasts window_i system cycles, and a value of 0 acts as 1. Both counters of every stage clear at window start, so only edges inside the window are counted. In the timeout case, done_o is high after RACE_TO+window+1 rising edges following the edge that sampled start.
- R9: resp_o[r] is the XOR of the stage bits r*XOR_K through r*XOR_K+XOR_K-1.
- R10: done_o is a one-cycle pulse, and resp_o is loaded at that pulse. resp_o holds its value until the next done pulse. busy_o falls in the cycle after done_o.
- R11: start_i received while busy_o is high is ignored. It produces no launch and does not alter the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| chal_i | input | N_STAGES*SEL_W | Challenge word, one path-select field per stage |
| window_i | input | WIN_W | Measurement window length in system cycles |
| path_a_i | input | N_STAGES*PATHS | Asynchronous A-side return edges, PATHS per stage |
| path_b_i | input | N_STAGES*PATHS | Asynchronous B-side return edges, PATHS per stage |
| ro_i | input | N_STAGES*4 | Asynchronous oscillator outputs, two pairs per stage |
| launch_o | output | 1 | One-cycle launch pulse for the delay paths |
| busy_o | output | 1 | High from the accepted start through the done cycle |
| done_o | output | 1 | One-cycle response-valid pulse |
| resp_o | output | RESP_W | XOR-folded response word |

## Verification
launch_o and busy_o are due one cycle after the edge that samples start. If any edge is missing, done_o is due RACE_TO+window+1 edges after that sampling edge. The bench drives every input on the falling edge and counts falling edges from the start drive until done appears. It compares that count against RACE_TO+window+2, which gives an exact latency check for the timeout case. The table runs have no fixed latency, so the bench waits for done and samples resp_o in that same half cycle. It then confirms one half-cycle later that done has dropped.

The bench drives each unselected path line with the opposite side's timing, so a wrong path selection would flip the arbiter bit. Ties are made exact by giving both oscillators of a pair the same period and phase.

// File: rtl/hrg_pkg.sv
package hrg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RACE,
    ST_MEAS,
    ST_CMP,
    ST_DONE
  } hrg_state_e;
endpackage

// File: rtl/hrg_sync.sv
module hrg_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hrg_arb_stage.sv
module hrg_arb_stage #(
  parameter int PATHS = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PATHS-1:0] path_a_i,
  input  logic [PATHS-1:0] path_b_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic             both_o,
  output logic             bit_o
);
  logic a_raw, b_raw, a_s, b_s;
  logic got_a, got_b, first_a;

  // select before sync: sel is static for the whole race
  assign a_raw = path_a_i[sel_i];
  assign b_raw = path_b_i[sel_i];

  hrg_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({b_raw, a_raw}),
    .q_o   ({b_s, a_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_a   <= 1'b0;
      got_b   <= 1'b0;
      first_a <= 1'b0;
    end else if (clr_i) begin
      got_a   <= 1'b0;
      got_b   <= 1'b0;
      first_a <= 1'b0;
    end else if (en_i) begin
      if (a_s) got_a <= 1'b1;
      if (b_s) got_b <= 1'b1;
      // A wins only alone and before any B
      if (a_s && !b_s && !got_a && !got_b) first_a <= 1'b1;
    end
  end

  assign both_o = got_a & got_b;
  assign bit_o  = got_a & got_b & first_a;

  assert_order_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (got_a && got_b && !clr_i) |=> $stable(bit_o));

  assert_tie_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !got_a && !got_b && a_s && b_s) |=> !bit_o);
endmodule

// File: rtl/hrg_ro_meter.sv
module hrg_ro_meter #(
  parameter int CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] ro_i,
  input  logic       sel_i,
  input  logic       clr_i,
  input  logic       en_i,
  output logic       bit_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [3:0] ro_s, ro_d, rise;
  logic       inc_a, inc_b;
  logic [CNT_W-1:0] cnt_a, cnt_b;

  // all four lines synced so a pair switch never fakes an edge
  hrg_sync #(.W(4)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ro_i),
    .q_o   (ro_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ro_d <= '0;
    else         ro_d <= ro_s;
  end

  assign rise  = ro_s & ~ro_d;
  assign inc_a = sel_i ? rise[2] : rise[0];
  assign inc_b = sel_i ? rise[3] : rise[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (clr_i) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (en_i) begin
      if (inc_a && cnt_a != CMAX) cnt_a <= cnt_a + 1'b1;
      if (inc_b && cnt_b != CMAX) cnt_b <= cnt_b + 1'b1;
    end
  end

  assign bit_o = cnt_a > cnt_b;

  assert_cnt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(cnt_a) && $stable(cnt_b)));

  assert_cnt_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_a == CMAX && !clr_i) |=> (cnt_a == CMAX));
endmodule

// File: rtl/hrg_ctrl.sv
module hrg_ctrl
  import hrg_pkg::*;
#(
  parameter int WIN_W   = 8,
  parameter int RACE_TO = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             all_both_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             arb_clr_o,
  output logic             arb_en_o,
  output logic             meas_clr_o,
  output logic             meas_en_o,
  output logic             cap_o
);
  localparam int TO_W = $clog2(RACE_TO);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(RACE_TO - 1);

  hrg_state_e       st_q;
  logic [TO_W-1:0]  rcnt_q;
  logic [WIN_W-1:0] win_q, wcnt_q, win_last;
  logic             launch_q, accept, race_end;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign race_end = (st_q == ST_RACE) && (all_both_i || rcnt_q == TO_LAST);
  assign win_last = (win_q == '0) ? '0 : win_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rcnt_q   <= '0;
      wcnt_q   <= '0;
      win_q    <= '0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= accept;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RACE;
          win_q  <= win_i;
          rcnt_q <= '0;
        end
        ST_RACE: begin
          rcnt_q <= rcnt_q + 1'b1;
          if (race_end) begin
            st_q   <= ST_MEAS;
            wcnt_q <= '0;
          end
        end
        ST_MEAS: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (wcnt_q == win_last) st_q <= ST_CMP;
        end
        ST_CMP:  st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign launch_o   = launch_q;
  assign busy_o     = st_q != ST_IDLE;
  assign done_o     = st_q == ST_DONE;
  assign arb_clr_o  = accept;
  assign arb_en_o   = st_q == ST_RACE;
  assign meas_clr_o = race_end;
  assign meas_en_o  = st_q == ST_MEAS;
  assign cap_o      = st_q == ST_CMP;

  assert_start_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (launch_o && busy_o));

  assert_launch_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);

  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !launch_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_timeout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RACE && rcnt_q == TO_LAST) |=> (st_q == ST_MEAS));
endmodule

// File: rtl/hybrid_resp_gen.sv
module hybrid_resp_gen #(
  parameter int RESP_W  = 2,
  parameter int XOR_K   = 2,
  parameter int PATHS   = 4,
  parameter int WIN_W   = 8,
  parameter int RACE_TO = 64,
  localparam int N_STAGES = RESP_W * XOR_K,
  localparam int SEL_W    = $clog2(PATHS),
  localparam int CHAL_W   = N_STAGES * SEL_W,
  localparam int CNT_W    = WIN_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [CHAL_W-1:0]         chal_i,
  input  logic [WIN_W-1:0]          window_i,
  input  logic [N_STAGES*PATHS-1:0] path_a_i,
  input  logic [N_STAGES*PATHS-1:0] path_b_i,
  input  logic [N_STAGES*4-1:0]     ro_i,
  output logic                      launch_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [RESP_W-1:0]         resp_o
);
  logic [CHAL_W-1:0]   chal_q;
  logic [N_STAGES-1:0] both, arb_bit, pair_bit;
  logic [RESP_W-1:0]   resp_d, resp_q;
  logic arb_clr, arb_en, meas_clr, meas_en, cap;

  hrg_ctrl #(.WIN_W(WIN_W), .RACE_TO(RACE_TO)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .win_i     (window_i),
    .all_both_i(&both),
    .launch_o  (launch_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .arb_clr_o (arb_clr),
    .arb_en_o  (arb_en),
    .meas_clr_o(meas_clr),
    .meas_en_o (meas_en),
    .cap_o     (cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chal_q <= '0;
    else if (arb_clr) chal_q <= chal_i;
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    hrg_arb_stage #(.PATHS(PATHS), .SEL_W(SEL_W)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (chal_q[s*SEL_W +: SEL_W]),
      .path_a_i(path_a_i[s*PATHS +: PATHS]),
      .path_b_i(path_b_i[s*PATHS +: PATHS]),
      .clr_i   (arb_clr),
      .en_i    (arb_en),
      .both_o  (both[s]),
      .bit_o   (arb_bit[s])
    );

    hrg_ro_meter #(.CNT_W(CNT_W)) u_meter (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ro_i  (ro_i[s*4 +: 4]),
      .sel_i (arb_bit[s]),
      .clr_i (meas_clr),
      .en_i  (meas_en),
      .bit_o (pair_bit[s])
    );
  end

  for (genvar r = 0; r < RESP_W; r++) begin : g_fold
    assign resp_d[r] = ^pair_bit[r*XOR_K +: XOR_K];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  resp_q <= '0;
    else if (cap) resp_q <= resp_d;
  end

  assign resp_o = resp_q;

  assert_resp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(resp_o) |-> done_o);
endmodule

// File: tb/hybrid_resp_gen_bench.sv
module hybrid_resp_gen_bench;
  localparam int T_TO = 64;

  typedef struct packed {
    logic [7:0]  chal;
    logic [19:0] ad;
    logic [19:0] bd;
    logic [31:0] roh;
    logic [7:0]  win;
  } vec_t;

  // ro half-period codes: 0 = held low, 1 = fast, 3 = slow
  localparam vec_t VECS [6] = '{
    '{8'h00, {5'd3,5'd3,5'd9,5'd3},   {5'd9,5'd9,5'd3,5'd9},   32'hD7D7D7D7, 8'd24},
    '{8'hE4, {5'd12,5'd2,5'd6,5'd4},  {5'd5,5'd8,5'd6,5'd10},  32'hD77DD7D5, 8'd30},
    '{8'h39, {5'd5,5'd5,5'd5,5'd5},   {5'd5,5'd5,5'd5,5'd5},   32'hD5D5D5D5, 8'd20},
    '{8'hC6, {5'd2,5'd7,5'd2,5'd7},   {5'd7,5'd0,5'd7,5'd0},   32'h7D7D7D7D, 8'd24},
    '{8'h1B, {5'd1,5'd20,5'd4,5'd15}, {5'd2,5'd3,5'd4,5'd16},  32'hD77DD57D, 8'd12},
    '{8'hFF, {5'd4,5'd4,5'd4,5'd4},   {5'd11,5'd11,5'd11,5'd11}, 32'h7DD77DD7, 8'd18}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] chal = '0;
  logic [7:0] win = '0;
  logic [15:0] path_a = '0, path_b = '0, ro = '0;
  logic launch, busy, done;
  logic [1:0] resp;

  logic [19:0] cur_ad = '0, cur_bd = '0;
  logic [31:0] cur_roh = '0;
  int cyc = 0, tcnt = 0, nlaunch = 0;
  logic armed = 1'b0;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  hybrid_resp_gen u_hybrid_resp_gen (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .chal_i  (chal),
    .window_i(win),
    .path_a_i(path_a),
    .path_b_i(path_b),
    .ro_i    (ro),
    .launch_o(launch),
    .busy_o  (busy),
    .done_o  (done),
    .resp_o  (resp)
  );

  // external oscillator and delay-path models
  always @(negedge clk) begin
    cyc++;
    for (int j = 0; j < 16; j++) begin
      int h;
      h = int'(cur_roh[2*j +: 2]);
      ro[j] = (h == 0) ? 1'b0 : (((cyc / h) % 2) == 1);
    end
    if (launch) begin
      armed = 1'b1; tcnt = 0; nlaunch++;
    end else if (done) begin
      armed = 1'b0;
    end else if (armed) begin
      tcnt++;
    end
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        int da, db;
        int a0, b0;
        a0 = int'(cur_ad[5*s +: 5]);
        b0 = int'(cur_bd[5*s +: 5]);
        // unselected lines carry swapped timing
        da = (p == int'(chal[2*s +: 2])) ? a0 : b0;
        db = (p == int'(chal[2*s +: 2])) ? b0 : a0;
        path_a[s*4+p] = armed && (da != 0) && (tcnt >= da);
        path_b[s*4+p] = armed && (db != 0) && (tcnt >= db);
      end
    end
  end

  function automatic int spd(input int h);
    return (h == 0) ? 0 : (h == 1) ? 3 : (h == 2) ? 2 : 1;
  endfunction

  function automatic logic [1:0] model(input logic [19:0] ad, input logic [19:0] bd,
                                       input logic [31:0] rh);
    logic [3:0] pb;
    for (int s = 0; s < 4; s++) begin
      int a, b, l1;
      logic arb;
      a = int'(ad[5*s +: 5]);
      b = int'(bd[5*s +: 5]);
      arb = (a != 0) && (b != 0) && (a < b);
      l1 = 4*s + (arb ? 2 : 0);
      pb[s] = spd(int'(rh[2*l1 +: 2])) > spd(int'(rh[2*(l1+1) +: 2]));
    end
    return {pb[3] ^ pb[2], pb[1] ^ pb[0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic run(input logic [7:0] c, input logic [19:0] ad, input logic [19:0] bd,
                     input logic [31:0] rh, input logic [7:0] w,
                     output int n, output logic [1:0] r, output bit done_one);
    @(negedge clk);
    chal = c; cur_ad = ad; cur_bd = bd; cur_roh = rh; win = w;
    start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
    end while (!done && n < 3000);
    r = resp;
    @(negedge clk);
    done_one = !done && !busy;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic [1:0] r;
    bit d1;
    int nl0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0 && launch == 1'b0, "R1 flags in reset", {busy, done, launch}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && launch == 1'b0, "R1 flags after reset", {busy, done, launch}, 0);
    chk(resp == 2'b00, "R1 resp after reset", resp, 0);

    // table walk: R3 mux, R4 order/tie, R5 timeout bit, R6 pair, R7 compare, R9 fold
    foreach (VECS[i]) begin
      logic [1:0] e;
      e = model(VECS[i].ad, VECS[i].bd, VECS[i].roh);
      run(VECS[i].chal, VECS[i].ad, VECS[i].bd, VECS[i].roh, VECS[i].win, n, r, d1);
      chk(r == e, $sformatf("R3 R4 R6 R7 R9 vector %0d resp", i), r, e);
      chk(d1, $sformatf("R10 vector %0d done width", i), d1, 1);
    end

    // R2 launch timing, R11 start while busy, R5 timeout latency
    @(negedge clk);
    chal = 8'h00; cur_ad = '0; cur_bd = '0; cur_roh = 32'h000D000D; win = 8'd10;
    nl0 = nlaunch;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(launch == 1'b1 && busy == 1'b1, "R2 launch and busy one cycle after start", {launch, busy}, 3);
    @(negedge clk);
    chk(launch == 1'b0, "R2 launch width", launch, 0);
    n = 2;
    repeat (18) begin @(negedge clk); n++; end
    start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(n == T_TO + 10 + 2, "R5 R11 timeout latency with stray start", n, T_TO + 12);
    chk(resp == 2'b11, "R5 timeout bit 0 selects pair0", resp, 3);
    repeat (6) @(negedge clk);
    chk(nlaunch - nl0 == 1, "R11 stray start gave no launch", nlaunch - nl0, 1);

    // R8 window length, zero acts as one
    run(8'h00, '0, '0, 32'h000D000D, 8'd0, n, r, d1);
    chk(n == T_TO + 1 + 2, "R8 window 0 latency", n, T_TO + 3);
    run(8'h00, '0, '0, 32'h000D000D, 8'd40, n, r, d1);
    chk(n == T_TO + 40 + 2, "R8 window 40 latency", n, T_TO + 42);

    // R10 hold, then R8 counter clear on the next run
    run(8'h00, '0, '0, 32'h000D000D, 8'd24, n, r, d1);
    chk(r == 2'b11, "R7 fast first oscillator", r, 3);
    cur_roh = 32'h0;
    repeat (10) @(negedge clk);
    chk(resp == 2'b11, "R10 resp held between runs", resp, 3);
    run(8'h00, '0, '0, 32'h000C000C, 8'd24, n, r, d1);
    chk(r == 2'b00, "R8 counters cleared at window start", r, 0);

    finish_run();
  end
endmodule